// File: doc/BRIEF.md
# Two-Level Periodic Interrupt Timer

This block produces periodic events on several timer channels from one clock. A small set of shared 8-bit micro timers divides the input clock into micro ticks. Each channel has a 16-bit down-counter that advances on the micro ticks of the micro timer picked by its own select bit. When a channel's count expires, the channel raises a sticky flag and reloads on its own, so the flag comes back at a fixed period. A registered interrupt request per channel is the flag gated by that channel's interrupt enable.

Software sets the block up through a simple write-only register bus while the global run bit is off: micro timer loads, channel loads, timer selects, channel enables and interrupt enables, in any order. It then sets the run bit. Software clears a flag by writing a one to its bit. Turning off a channel enable, an interrupt enable or the global run bit also clears the affected flags. Software can therefore stop a channel and be sure that no old event remains.

Top module: `periodic_irq_timer`

## Requirements
- R1: A micro timer with load value M produces one micro tick every M+1 input clock cycles while the block runs.
- R2: A channel with load value L sets its flag once every L+1 micro ticks of its selected micro timer. The first flag is visible (L+1)*(M+1) cycles after the clock edge that sets the run bit. The counter reloads by itself, so later flags follow at the same period.
- R3: Select bit i of the select register picks the micro timer of channel i: 0 picks micro timer 0 and 1 picks micro timer 1.
- R4: A write to the flag register clears the flags whose data bits are one, from the next cycle. Bits written as zero leave their flags unchanged. If a flag is set in the same cycle as a clearing write, the set wins.
- R5: When a 1-to-0 write hits channel enable bit i or interrupt enable bit i, flag i is zero from the next cycle. When the run bit goes from 1 to 0, all flags are zero from the next cycle. This clearing wins over a flag set in the same cycle.
- R6: irq_o[i] equals flag i AND interrupt enable i, as they stood one cycle earlier.
- R7: While the run bit is 0, no counter advances and no flag is set. Configuration writes then take effect in any order.
- R8: After reset, all enables, selects, flags and interrupt requests are zero, and every load register is zero. A channel enabled without any load write therefore flags on every cycle.
- R9: A channel whose enable bit is 0 never sets its flag.
- R10: Register map, with channel i at data bit i in registers 1 to 4. Address 0 bit 0 is the run bit. Address 1 holds the channel enables. Address 2 holds the interrupt enables. Address 3 holds the timer selects. Address 4 is the flag clear register. Address 6+j holds the load of micro timer j. Address 8+i holds the load of channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | DATA_W (16) | Register write data |
| flag_o | output | NCH (4) | Sticky per-channel expiry flags |
| irq_o | output | NCH (4) | Registered per-channel interrupt requests |

## Verification
The bench builds the block with its default parameters: four channels, two micro timers, 8-bit micro loads and 16-bit channel loads. With these values, both timer selects, a disabled channel and the all-zero reset loads can be tested side by side. Small load values keep the first-expiry, reload and same-cycle corner cases within a few hundred cycles. The scoreboard checks flags and requests at exact cycles counted from the run edge. These checks cover clear-on-write, clear-on-disable and the halt while the run bit is off.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_CHEN = 1;
    localparam int unsigned ADDR_IEN  = 2;
    localparam int unsigned ADDR_SEL  = 3;
    localparam int unsigned ADDR_FLAG = 4;
    localparam int unsigned MT_BASE   = 6;
    localparam int unsigned CH_BASE   = 8;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] load,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run || s_q.cnt == '0) s_d.cnt = load;
        else                       s_d.cnt = s_q.cnt - W'(1);
    end

    assign tick = run && (s_q.cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: after a tick the divider restarts from the load value
    assert_tick_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> s_q.cnt == $past(load));
    // R1: between ticks the divider steps down by exactly one
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> s_q.cnt == $past(s_q.cnt) - W'(1));
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] load,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run)                 s_d.cnt = load;
        else if (tick) begin
            if (s_q.cnt == '0)    s_d.cnt = load;
            else                  s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    assign expire = run && tick && (s_q.cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: expiry reloads the count in the same step
    assert_expire_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> s_q.cnt == $past(load));
    // R2: the count only moves on a selected micro tick
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(s_q.cnt));
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
    import ptmr_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned NMT    = 2,
    parameter int unsigned MT_W   = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    flag_o,
    output logic [NCH-1:0]    irq_o
);
    localparam int unsigned SEL_W = (NMT > 1) ? $clog2(NMT) : 1;

    typedef struct packed {
        logic                           run;
        logic [NCH-1:0]                 chen;
        logic [NCH-1:0]                 ien;
        logic [NCH-1:0][SEL_W-1:0]      sel;
        logic [NCH-1:0]                 flag;
        logic [NCH-1:0]                 irq;
        logic [NMT-1:0][MT_W-1:0]       mt_load;
        logic [NCH-1:0][CNT_W-1:0]      ch_load;
    } regs_t;

    regs_t          r_d, r_q;
    logic [NMT-1:0] tick;
    logic [NCH-1:0] expire;
    logic [NCH-1:0] clr_w;
    logic [NCH-1:0] drop;

    for (genvar j = 0; j < NMT; j++) begin : g_mt
        ptmr_prescaler #(.W(MT_W)) u_mt (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (r_q.run),
            .load (r_q.mt_load[j]),
            .tick (tick[j])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ptmr_channel #(.CW(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (r_q.run & r_q.chen[i]),
            .tick  (tick[r_q.sel[i]]),
            .load  (r_q.ch_load[i]),
            .expire(expire[i])
        );
    end

    always_comb begin
        r_d   = r_q;
        clr_w = '0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL)) r_d.run  = wr_data[0];
            if (wr_addr == ADDR_W'(ADDR_CHEN)) r_d.chen = wr_data[NCH-1:0];
            if (wr_addr == ADDR_W'(ADDR_IEN))  r_d.ien  = wr_data[NCH-1:0];
            if (wr_addr == ADDR_W'(ADDR_SEL))  r_d.sel  = wr_data[NCH*SEL_W-1:0];
            if (wr_addr == ADDR_W'(ADDR_FLAG)) clr_w    = wr_data[NCH-1:0];
            for (int j = 0; j < NMT; j++)
                if (wr_addr == ADDR_W'(MT_BASE + j)) r_d.mt_load[j] = wr_data[MT_W-1:0];
            for (int i = 0; i < NCH; i++)
                if (wr_addr == ADDR_W'(CH_BASE + i)) r_d.ch_load[i] = wr_data[CNT_W-1:0];
        end
        // an enable going from one to zero wipes the affected flags
        drop = (r_q.chen & ~r_d.chen) | (r_q.ien & ~r_d.ien)
             | {NCH{r_q.run & ~r_d.run}};
        r_d.flag = ((r_q.flag & ~clr_w) | expire) & ~drop;
        r_d.irq  = r_q.flag & r_q.ien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flag_o = r_q.flag;
    assign irq_o  = r_q.irq;

    // R5: stopping the block leaves no flag behind
    assert_run_off_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.run) |-> r_q.flag == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R4: a one written to a flag bit clears it unless it expires again
        assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(ADDR_FLAG) && wr_data[i] && !expire[i])
            |=> !flag_o[i]);
        // R6: request follows flag and interrupt enable one cycle later
        assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq_o[i] == $past(r_q.flag[i] & r_q.ien[i]));
        // R5: interrupt enable or channel enable falling clears the flag
        assert_ien_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(r_q.ien[i]) || $fell(r_q.chen[i])) |-> !r_q.flag[i]);
        // R7: nothing gets flagged while the block is stopped
        assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !r_q.run |=> !(r_q.flag[i] && !$past(r_q.flag[i])));
        // R2: a flag only rises after the channel expired
        assert_rise_on_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(r_q.flag[i]) |-> $past(expire[i]));
    end
endmodule

// File: tb/test_periodic_irq_timer.sv
module test_periodic_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  flag_o;
    logic [3:0]  irq_o;

    always #10 clk = ~clk;

    periodic_irq_timer i_periodic_irq_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_o(flag_o), .irq_o(irq_o)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int       cyc;
        logic [3:0] fl;
        logic [3:0] ir;
        bit       chk_ir;
        string    tag;
    } exp_t;
    exp_t q[$];

    task automatic expect_at(input int c, input logic [3:0] fl, input logic [3:0] ir,
                             input bit ci, input string tag);
        exp_t e;
        e.cyc = c; e.fl = fl; e.ir = ir; e.chk_ir = ci; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares scheduled expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc < cyc) begin
            checks++; errors++;
            $display("FAIL %s missed sample at cycle %0d", q[0].tag, q[0].cyc);
            void'(q.pop_front());
        end
        if (q.size() > 0 && q[0].cyc == cyc) begin
            checks++;
            if (flag_o !== q[0].fl) begin
                errors++;
                $display("FAIL %s cycle %0d flags actual %b expected %b",
                         q[0].tag, cyc, flag_o, q[0].fl);
            end
            if (q[0].chk_ir) begin
                checks++;
                if (irq_o !== q[0].ir) begin
                    errors++;
                    $display("FAIL %s cycle %0d irq actual %b expected %b",
                             q[0].tag, cyc, irq_o, q[0].ir);
                end
            end
            void'(q.pop_front());
        end
    end

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // write captured by the edge that makes cyc equal to e
    task automatic wr_at(input int e, input logic [3:0] a, input logic [15:0] d);
        while (cyc < e - 1) @(negedge clk);
        wr(a, d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flag_o, 4'b0000, "R8 reset flags");
        chk(irq_o,  4'b0000, "R8 reset irq");

        // zero reset loads: channel 0 expires every cycle (R8, R10 map)
        wr(4'd1, 16'h0001);
        wr(4'd0, 16'h0001);
        w = cyc;
        expect_at(w + 1, 4'b0001, 4'b0000, 1'b0, "R8 zero loads flag at once");
        expect_at(w + 2, 4'b0001, 4'b0000, 1'b1, "R6 request masked by ien");
        expect_at(w + 4, 4'b0000, 4'b0000, 1'b0, "R5 run off clears flag");
        wr_at(w + 4, 4'd0, 16'h0000);
        wr(4'd1, 16'h0000);

        // mixed selects, one disabled channel (R1 R3 R9 R7)
        wr(4'd10, 16'd1);
        wr(4'd8,  16'd2);
        wr(4'd7,  16'd1);
        wr(4'd9,  16'd4);
        wr(4'd6,  16'd3);
        wr(4'd11, 16'd0);
        wr(4'd3,  16'b0110);
        wr(4'd2,  16'b0101);
        wr(4'd1,  16'b0111);
        wr(4'd0,  16'h0001);
        w = cyc;
        expect_at(w + 3,  4'b0000, 4'b0000, 1'b1, "R1 before first tick chain");
        expect_at(w + 4,  4'b0100, 4'b0000, 1'b0, "R3 ch2 on timer1 period 4");
        expect_at(w + 5,  4'b0100, 4'b0100, 1'b1, "R6 ch2 request");
        expect_at(w + 9,  4'b0100, 4'b0100, 1'b1, "R1 ch1 not yet");
        expect_at(w + 10, 4'b0110, 4'b0100, 1'b1, "R1 ch1 timer1 period 10");
        expect_at(w + 11, 4'b0110, 4'b0100, 1'b1, "R6 ch1 masked");
        expect_at(w + 12, 4'b0111, 4'b0100, 1'b1, "R3 ch0 timer0 period 12");
        expect_at(w + 13, 4'b0111, 4'b0101, 1'b1, "R6 ch0 request");
        expect_at(w + 19, 4'b0111, 4'b0101, 1'b1, "R9 disabled ch3 silent");
        expect_at(w + 20, 4'b0000, 4'b0101, 1'b1, "R5 run off clears all");
        expect_at(w + 21, 4'b0000, 4'b0000, 1'b1, "R6 request drops");
        expect_at(w + 50, 4'b0000, 4'b0000, 1'b1, "R7 no counting while off");
        wr_at(w + 20, 4'd0, 16'h0000);
        while (cyc < w + 52) @(negedge clk);

        // reload, write-one-to-clear and enable drops (R2 R4 R5)
        wr(4'd8, 16'd9);
        wr(4'd9, 16'd3);
        wr(4'd6, 16'd9);
        wr(4'd7, 16'd4);
        wr(4'd3, 16'b0010);
        wr(4'd2, 16'b0011);
        wr(4'd1, 16'b0011);
        wr(4'd0, 16'h0001);
        w = cyc;
        expect_at(w + 19,  4'b0000, 4'b0000, 1'b1, "R2 ch1 before first expiry");
        expect_at(w + 20,  4'b0010, 4'b0000, 1'b0, "R2 ch1 first expiry");
        expect_at(w + 21,  4'b0010, 4'b0010, 1'b1, "R6 ch1 request");
        expect_at(w + 99,  4'b0010, 4'b0010, 1'b1, "R2 ch0 before expiry");
        expect_at(w + 100, 4'b0011, 4'b0010, 1'b1, "R2 ch0 period 100");
        expect_at(w + 101, 4'b0011, 4'b0011, 1'b1, "R6 both requests");
        expect_at(w + 105, 4'b0011, 4'b0011, 1'b0, "R4 zero write no effect");
        expect_at(w + 110, 4'b0010, 4'b0011, 1'b0, "R4 clear only bit 0");
        expect_at(w + 199, 4'b0010, 4'b0010, 1'b1, "R2 ch0 waits a full period");
        expect_at(w + 200, 4'b0011, 4'b0010, 1'b0, "R2 ch0 reload repeats");
        expect_at(w + 205, 4'b0001, 4'b0011, 1'b0, "R4 clear only bit 1");
        expect_at(w + 219, 4'b0001, 4'b0001, 1'b1, "R2 ch1 waits");
        expect_at(w + 220, 4'b0011, 4'b0001, 1'b0, "R2 ch1 reload repeats");
        expect_at(w + 230, 4'b0010, 4'b0011, 1'b0, "R5 ien drop clears ch0");
        expect_at(w + 231, 4'b0010, 4'b0010, 1'b1, "R6 after ien drop");
        expect_at(w + 245, 4'b0000, 4'b0010, 1'b0, "R5 chen drop clears ch1");
        expect_at(w + 246, 4'b0000, 4'b0000, 1'b1, "R6 after chen drop");
        expect_at(w + 299, 4'b0000, 4'b0000, 1'b1, "R9 ch1 stays idle");
        expect_at(w + 300, 4'b0001, 4'b0000, 1'b0, "R2 ch0 counts with ien off");
        expect_at(w + 301, 4'b0001, 4'b0000, 1'b1, "R6 masked ch0 request");
        expect_at(w + 310, 4'b0000, 4'b0000, 1'b1, "R5 run off clears ch0");
        expect_at(w + 340, 4'b0000, 4'b0000, 1'b1, "R7 still halted");
        wr_at(w + 105, 4'd4, 16'b0000);
        wr_at(w + 110, 4'd4, 16'b0001);
        wr_at(w + 205, 4'd4, 16'b0010);
        wr_at(w + 230, 4'd2, 16'b0010);
        wr_at(w + 245, 4'd1, 16'b0001);
        wr_at(w + 310, 4'd0, 16'h0000);

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule